// File: doc/BRIEF.md
# Scanned Thumbwheel Store Loader

This block fills three six-digit BCD registers (preset, presignal and main signal) from a single 4-bit BCD input, one decade at a time. It owns the digit-scan sequence: a one-hot digit-select vector walks from the most significant digit down to the least significant and then wraps. The same vector drives a bank of thumbwheel switches, so the switch for the active digit places its value on the shared BCD input. The same vector also paces the display multiplexing elsewhere on the chip.

Each digit slot lasts a fixed number of scan-clock enables. The write happens at a single strobe in the middle of the slot, well away from either select edge. The strobe writes the BCD input into the digit position of the store named by a two-bit select code. Code 00 writes nothing. If a code is held for one complete six-slot scan, the whole store is loaded. Open switches are pulled low on the board, so an undriven digit is written as zero. Counting and segment encoding are handled by other blocks.

Top module: `tw_store_loader`

## Requirements
- R1: After reset, all three stores read zero and the digit select shows the most significant digit (bit 5 high, all other bits low).
- R2: Exactly one digit-select bit is high at every cycle outside reset.
- R3: The digit select moves down one bit position (from bit 5 toward bit 0) after every SLOT_TICKS scan enables (default 4). After bit 0 it returns to bit 5.
- R4: In a cycle with scan_en low, neither the digit select nor any store changes, whatever the data and select inputs are.
- R5: The select code {sel_a, sel_b} picks the target store: 10 selects presignal, 01 selects main signal, 11 selects preset, and 00 selects no store.
- R6: A write happens only on the scan enable whose position in the slot is SLOT_TICKS/2, counted from 0 (the third enable of a four-enable slot). Data and select values on every other enable are ignored.
- R7: A write stores bcd_in into the nibble of the active digit. The most significant digit sits in bits [23:20] and the least significant in bits [3:0]. No other nibble and no other store changes.
- R8: Holding one select code across one full scan, starting at the most significant slot, loads all six digits of that store.
- R9: The select code and data are taken from the strobe cycle itself. Values that change in that very cycle take effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset; released synchronously inside the block |
| scan_en | input | 1 | One-cycle enable derived from the scan clock |
| bcd_in | input | 4 | BCD digit from the thumbwheel switches |
| sel_a | input | 1 | Storage select, first bit of the code |
| sel_b | input | 1 | Storage select, second bit of the code |
| digit_sel | output | 6 | One-hot active digit; bit 5 is the most significant digit |
| preset_store | output | 24 | Preset store, six BCD digits |
| presig_store | output | 24 | Presignal store, six BCD digits |
| main_store | output | 24 | Main signal store, six BCD digits |

## Verification
The write strobe and a change of the select code or data can land on the same clock edge. The design must use the values present on that edge, not those of the preceding enable. To provoke this, the bench drives every off-strobe enable with the complement code and different data, then switches to the intended code and digit exactly on the strobe enable. The result is judged by comparing every store against an arithmetic model after each enable. A write that lands one enable early or late shows up as a wrong nibble or a write to the wrong store.

// File: rtl/tw_loader_pkg.sv
package tw_loader_pkg;

  localparam int NUM_STORES = 3;

  localparam int IX_PRESET = 0;
  localparam int IX_PRESIG = 1;
  localparam int IX_MAIN   = 2;

  typedef enum logic [1:0] {
    TGT_NONE   = 2'b00,
    TGT_MAIN   = 2'b01,
    TGT_PRESIG = 2'b10,
    TGT_PRESET = 2'b11
  } target_e;

endpackage

// File: rtl/tw_scan_seq.sv
module tw_scan_seq #(
  parameter int DIGITS     = 6,
  parameter int SLOT_TICKS = 4,
  localparam int IDX_W     = (DIGITS > 1) ? $clog2(DIGITS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scan_en,
  output logic [DIGITS-1:0] digit_sel,
  output logic [IDX_W-1:0]  dig_idx,
  output logic              strobe
);

  localparam int TICK_W = (SLOT_TICKS > 1) ? $clog2(SLOT_TICKS) : 1;
  localparam logic [TICK_W-1:0] MID_T  = TICK_W'(SLOT_TICKS / 2);
  localparam logic [TICK_W-1:0] LAST_T = TICK_W'(SLOT_TICKS - 1);
  localparam logic [IDX_W-1:0]  LAST_D = IDX_W'(DIGITS - 1);

  logic [TICK_W-1:0] tick_q, tick_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic              slot_end;

  assign slot_end = scan_en && (tick_q == LAST_T);
  assign strobe   = scan_en && (tick_q == MID_T);

  always_comb begin
    tick_d = tick_q;
    idx_d  = idx_q;
    if (scan_en) begin
      if (tick_q == LAST_T) begin
        tick_d = '0;
      end else begin
        tick_d = tick_q + TICK_W'(1);
      end
    end
    if (slot_end) begin
      if (idx_q == LAST_D) begin
        idx_d = '0;
      end else begin
        idx_d = idx_q + IDX_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick_q <= '0;
      idx_q  <= '0;
    end else begin
      tick_q <= tick_d;
      idx_q  <= idx_d;
    end
  end

  assign dig_idx = idx_q;

  // slot 0 is the most significant digit, driven on the top bit
  for (genvar g = 0; g < DIGITS; g++) begin : g_sel
    assign digit_sel[DIGITS-1-g] = (idx_q == IDX_W'(g));
  end

  AST_DIGIT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(digit_sel) == 1); // R2

  AST_DIGIT_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !scan_en |=> $stable(digit_sel)); // R4

  AST_DIGIT_STEP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(digit_sel) |-> ((digit_sel == ($past(digit_sel) >> 1)) ||
                             (($past(digit_sel) == DIGITS'(1)) &&
                              digit_sel[DIGITS-1]))); // R3

endmodule

// File: rtl/tw_select_dec.sv
module tw_select_dec
  import tw_loader_pkg::*;
(
  input  logic                  strobe,
  input  logic [1:0]            code,
  output logic [NUM_STORES-1:0] we
);

  always_comb begin
    we = '0;
    if (strobe) begin
      unique case (target_e'(code))
        TGT_PRESET: we[IX_PRESET] = 1'b1;
        TGT_PRESIG: we[IX_PRESIG] = 1'b1;
        TGT_MAIN:   we[IX_MAIN]   = 1'b1;
        default:    we = '0;
      endcase
    end
  end

endmodule

// File: rtl/tw_store_bank.sv
module tw_store_bank #(
  parameter int DIGITS  = 6,
  parameter int DIGIT_W = 4,
  localparam int IDX_W  = (DIGITS > 1) ? $clog2(DIGITS) : 1,
  localparam int STORE_W = DIGITS * DIGIT_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we,
  input  logic [IDX_W-1:0]   dig_idx,
  input  logic [DIGIT_W-1:0] data,
  output logic [STORE_W-1:0] store
);

  for (genvar g = 0; g < DIGITS; g++) begin : g_dig
    logic [DIGIT_W-1:0] dq, dd;
    logic               hit;

    assign hit = we && (dig_idx == IDX_W'(g));

    always_comb begin
      dd = dq;
      if (hit) begin
        dd = data;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        dq <= '0;
      end else begin
        dq <= dd;
      end
    end

    assign store[(DIGITS-1-g)*DIGIT_W +: DIGIT_W] = dq;

    AST_DIGIT_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
      (we && (dig_idx == IDX_W'(g))) |=>
        (store[(DIGITS-1-g)*DIGIT_W +: DIGIT_W] == $past(data))); // R7
  end

  AST_STORE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(store)); // R6

endmodule

// File: rtl/tw_store_loader.sv
module tw_store_loader
  import tw_loader_pkg::*;
#(
  parameter int DIGITS     = 6,
  parameter int DIGIT_W    = 4,
  parameter int SLOT_TICKS = 4,
  localparam int STORE_W   = DIGITS * DIGIT_W,
  localparam int IDX_W     = (DIGITS > 1) ? $clog2(DIGITS) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scan_en,
  input  logic [DIGIT_W-1:0] bcd_in,
  input  logic               sel_a,
  input  logic               sel_b,
  output logic [DIGITS-1:0]  digit_sel,
  output logic [STORE_W-1:0] preset_store,
  output logic [STORE_W-1:0] presig_store,
  output logic [STORE_W-1:0] main_store
);

  logic [1:0]            rst_sync_q;
  logic                  rst_int_n;
  logic [IDX_W-1:0]      dig_idx;
  logic                  strobe;
  logic [1:0]            code;
  logic [NUM_STORES-1:0] we;
  logic [STORE_W-1:0]    bank_q [NUM_STORES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end

  assign rst_int_n = rst_sync_q[1];
  assign code      = {sel_a, sel_b};

  tw_scan_seq #(
    .DIGITS     (DIGITS),
    .SLOT_TICKS (SLOT_TICKS)
  ) i_seq (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .scan_en   (scan_en),
    .digit_sel (digit_sel),
    .dig_idx   (dig_idx),
    .strobe    (strobe)
  );

  tw_select_dec i_dec (
    .strobe (strobe),
    .code   (code),
    .we     (we)
  );

  for (genvar s = 0; s < NUM_STORES; s++) begin : g_bank
    tw_store_bank #(
      .DIGITS  (DIGITS),
      .DIGIT_W (DIGIT_W)
    ) i_bank (
      .clk     (clk),
      .rst_n   (rst_int_n),
      .we      (we[s]),
      .dig_idx (dig_idx),
      .data    (bcd_in),
      .store   (bank_q[s])
    );
  end

  assign preset_store = bank_q[IX_PRESET];
  assign presig_store = bank_q[IX_PRESIG];
  assign main_store   = bank_q[IX_MAIN];

  AST_IDLE_CODE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_int_n)
    (code == 2'b00) |=> ($stable(preset_store) && $stable(presig_store) &&
                         $stable(main_store))); // R5

  AST_NO_ENABLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_int_n)
    !scan_en |=> ($stable(preset_store) && $stable(presig_store) &&
                  $stable(main_store))); // R4

endmodule

// File: tb/test_tw_store_loader.sv
module test_tw_store_loader;

  localparam int DIG  = 6;
  localparam int SLOT = 4;
  localparam int MID  = SLOT / 2;

  logic        clk;
  logic        rst_n;
  logic        scan_en;
  logic [3:0]  bcd_in;
  logic        sel_a;
  logic        sel_b;
  logic [5:0]  digit_sel;
  logic [23:0] preset_store;
  logic [23:0] presig_store;
  logic [23:0] main_store;

  int n_chk;
  int n_bad;
  int pos;
  bit done;
  logic [23:0] exp_st [3];

  tw_store_loader i_tw_store_loader (
    .clk          (clk),
    .rst_n        (rst_n),
    .scan_en      (scan_en),
    .bcd_in       (bcd_in),
    .sel_a        (sel_a),
    .sel_b        (sel_b),
    .digit_sel    (digit_sel),
    .preset_store (preset_store),
    .presig_store (presig_store),
    .main_store   (main_store)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [5:0] exp_sel();
    return 6'(1 << (DIG - 1 - ((pos / SLOT) % DIG)));
  endfunction

  task automatic check_all(input string req);
    check({req, " digit_sel"}, 32'(digit_sel), 32'(exp_sel()));
    check("R2 one-hot", 32'($countones(digit_sel)), 32'd1);
    check({req, " preset"}, 32'(preset_store), 32'(exp_st[0]));
    check({req, " presig"}, 32'(presig_store), 32'(exp_st[1]));
    check({req, " main"},   32'(main_store),   32'(exp_st[2]));
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    scan_en = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    pos = 0;
    for (int s = 0; s < 3; s++) exp_st[s] = '0;
  endtask

  // one scan enable; model writes only at the mid-slot strobe
  task automatic pulse(input logic [3:0] d, input logic [1:0] code);
    int slot;
    bit stb;
    slot = (pos / SLOT) % DIG;
    stb  = ((pos % SLOT) == MID);
    @(negedge clk);
    bcd_in = d;
    {sel_a, sel_b} = code;
    scan_en = 1'b1;
    @(negedge clk);
    scan_en = 1'b0;
    if (stb) begin
      case (code)
        2'b11: exp_st[0][4*(DIG-1-slot) +: 4] = d;
        2'b10: exp_st[1][4*(DIG-1-slot) +: 4] = d;
        2'b01: exp_st[2][4*(DIG-1-slot) +: 4] = d;
        default: ;
      endcase
    end
    pos++;
    if (stb) check_all("R7/R9");
    else     check_all("R6");
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    n_chk = 0;
    n_bad = 0;
    pos = 0;
    done = 1'b0;
    rst_n = 1'b0;
    scan_en = 1'b0;
    bcd_in = 4'd0;
    sel_a = 1'b0;
    sel_b = 1'b0;
    for (int s = 0; s < 3; s++) exp_st[s] = '0;

    do_reset();
    check("R1 digit_sel", 32'(digit_sel), 32'h20);
    check("R1 preset", 32'(preset_store), 32'h0);
    check("R1 presig", 32'(presig_store), 32'h0);
    check("R1 main",   32'(main_store),   32'h0);

    // R5 R8: every code over one full scan; off-strobe enables carry the
    // complement code and other data, which must be ignored (R6)
    for (int pass = 0; pass < 2; pass++) begin
      for (int c = 0; c < 4; c++) begin
        logic [23:0] full;
        full = '0;
        for (int d = 0; d < DIG; d++) begin
          logic [3:0] v;
          v = 4'((d * 3 + c + 1 + pass * 5) % 10);
          full[4*(DIG-1-d) +: 4] = v;
          for (int t = 0; t < SLOT; t++) begin
            if (t == MID) pulse(v, 2'(c));
            else          pulse(4'((v + 5) % 10), 2'(c) ^ 2'b11);
          end
        end
        case (c)
          3: check("R8 preset full", 32'(preset_store), 32'(full));
          2: check("R8 presig full", 32'(presig_store), 32'(full));
          1: check("R8 main full",   32'(main_store),   32'(full));
          default: check("R5 idle code digit_sel", 32'(digit_sel), 32'h20);
        endcase
      end
    end

    // R4: no enable, changing inputs, nothing moves
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      bcd_in = 4'(k % 10);
      {sel_a, sel_b} = 2'(k);
      scan_en = 1'b0;
      @(negedge clk);
      check_all("R4");
    end

    // R3: walk a full wrap with code 00, digit_sel checked each enable
    for (int k = 0; k < SLOT * DIG + SLOT; k++) pulse(4'd7, 2'b00);

    // R1: reset mid-scan clears everything
    pulse(4'd9, 2'b11);
    do_reset();
    check("R1 digit_sel", 32'(digit_sel), 32'h20);
    check("R1 preset", 32'(preset_store), 32'h0);
    check("R1 presig", 32'(presig_store), 32'h0);
    check("R1 main",   32'(main_store),   32'h0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule